// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from normal execution into an exception handler. It watches four request lines: bus fault, trap, maskable interrupt and non-maskable interrupt. In a cycle where it is idle, it accepts the highest-priority request that is currently allowed. A maskable interrupt is allowed only when the interrupt-enable flag is set and no lock is active. A non-maskable interrupt is allowed only when its enable flag is set. Faults and traps are always allowed.

On acceptance the block takes a snapshot of the core's register values and, one cycle later, issues single-cycle write-back strobes with the new values:
- the return address, which goes to the exception or the non-maskable return register;
- the exception-status index;
- the shifted condition-code stack word;
- when leaving user mode, the user and kernel stack pointers;
- a clear of the delay-slot indicator.

In the same cycle it starts a read of the handler address from a vector table at base plus four times the vector. It holds the read request until memory answers. One cycle after the answer it writes the program counter, pulses done and clears the core's pending-exception index.

The core treats `busy` as the window in which no further request can be taken. It must drop a request once that request has been accepted, or at the latest when `excp_clr` pulses.

Top module: `exc_entry_seq`

## Requirements
- R1: A bus-fault request is always accepted when the block is idle. Its vector is `fault_vec`, and `erp_wd` receives the return address.
- R2: A trap request is accepted when the block is idle. Its vector is `trap_vec`, and `erp_wd` receives the return address.
- R3: A maskable interrupt is accepted only when `irq_req` is high, CCS bit `I_BIT` (default 4) is set and `irq_lock` is low. Its vector is `irq_vec`. Otherwise it is ignored: no write strobe, no read and `busy` stays low.
- R4: A non-maskable interrupt is accepted only when CCS bit `M_BIT` (default 9) is set. Its vector is 0 and `nrp_we` saves `cur_pc` unchanged into `nrp_wd`. `erp_we` stays low, and bit `M_BIT` is cleared before the CCS shift.
- R5: Priority among allowed requests, highest first: bus fault, trap, maskable interrupt, non-maskable interrupt.
- R6: `exs_wd` holds the low 8 bits of the vector in bits 15:8, and all other bits are zero. `exs_we` pulses on every entry.
- R7: For fault, trap and interrupt entries, `erp_wd = cur_pc - dslot_cnt`. `dslot_clr` pulses on every entry.
- R8: If CCS bit `U_BIT` (default 8) is set, `usp_wd = cur_sp` and `sp_wd = kern_sp`, with `usp_we` and `sp_we` pulsing. Otherwise both strobes stay low.
- R9: `ccs_wd` keeps CCS bits 31:30, places CCS bits 19:0 in bits 29:10, and has bits 9:0 zero.
- R10: All entry strobes pulse for one cycle, one cycle after acceptance. In that same cycle `busy` and `mem_rd_valid` rise, with `mem_rd_addr = cur_ebp + 4*vector`. Both `mem_rd_valid` and the address hold until `mem_rd_ready` is high.
- R11: The cycle after `mem_rd_valid && mem_rd_ready`, `pc_we`, `done` and `excp_clr` pulse for one cycle, with `pc_wd` equal to the `mem_rd_data` seen at the handshake. In that cycle `busy` is low. After reset, all strobes, `busy` and `mem_rd_valid` are low.
- R12: Requests that arrive while `busy` is high are ignored: they produce no entry strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_req | input | 1 | Bus-fault request |
| fault_vec | input | VW | Bus-fault vector |
| trap_req | input | 1 | Trap/break request |
| trap_vec | input | VW | Trap vector |
| irq_req | input | 1 | Maskable interrupt pending |
| irq_vec | input | VW | Interrupt controller vector |
| irq_lock | input | 1 | Interrupt lock active |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| cur_pc | input | DW | Current program counter |
| cur_sp | input | DW | Current stack pointer |
| cur_ccs | input | DW | Current condition-code stack |
| cur_ebp | input | DW | Exception vector table base |
| kern_sp | input | DW | Kernel stack pointer |
| dslot_cnt | input | DSW | Delay-slot indicator (0 = none) |
| erp_we | output | 1 | Exception return register write |
| erp_wd | output | DW | Exception return value |
| nrp_we | output | 1 | NMI return register write |
| nrp_wd | output | DW | NMI return value |
| exs_we | output | 1 | Exception status write |
| exs_wd | output | DW | Exception status value |
| ccs_we | output | 1 | CCS write |
| ccs_wd | output | DW | Shifted CCS value |
| usp_we | output | 1 | User stack pointer write |
| usp_wd | output | DW | Saved user stack pointer |
| sp_we | output | 1 | Stack pointer write |
| sp_wd | output | DW | Kernel stack pointer to load |
| dslot_clr | output | 1 | Clear delay-slot indicator |
| mem_rd_valid | output | 1 | Vector table read request |
| mem_rd_addr | output | DW | Vector table read address |
| mem_rd_ready | input | 1 | Read accepted, data valid |
| mem_rd_data | input | DW | Handler address read |
| pc_we | output | 1 | Program counter write |
| pc_wd | output | DW | Handler address |
| excp_clr | output | 1 | Clear pending exception index |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Entry complete |

## Verification
The bench builds the block with its defaults: 32-bit words, 8-bit vectors, a 2-bit delay-slot indicator, and the I, M and U flags at bits 4, 9 and 8. With that configuration it sweeps all sixteen combinations of the four request lines against all four enable-flag settings and both lock states. This covers every priority and masking outcome.

The narrow vector and delay-slot fields also let it walk all 256 trap vectors for the table address and status field, and every delay-slot value with the user flag both set and clear. Read latencies from zero to three cycles exercise the held read request.

// File: rtl/exc_entry_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package exc_entry_pkg;

    // Which request the arbiter picked; NONE means nothing is taken.
    typedef enum logic [2:0] {
        EK_NONE  = 3'd0,
        EK_FAULT = 3'd1,
        EK_TRAP  = 3'd2,
        EK_IRQ   = 3'd3,
        EK_NMI   = 3'd4
    } exc_kind_e;

    // Width of the shift applied to the condition-code stack.
    localparam int CCS_SHIFT = 10;
    // Width of the exception-status index field and its low bit.
    localparam int EXS_IDX_W  = 8;
    localparam int EXS_IDX_LO = 8;

endpackage

// File: rtl/exc_arbiter.sv
// Request arbiter: applies enable/lock masking and fixed priority
// (fault > trap > maskable irq > nmi), and returns the kind and vector.
// Assumes: the caller already gated with the sequencer's busy state.
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          fault_req,
    input  logic [VW-1:0] fault_vec,
    input  logic          trap_req,
    input  logic [VW-1:0] trap_vec,
    input  logic          irq_req,
    input  logic [VW-1:0] irq_vec,
    input  logic          irq_lock,
    input  logic          irq_en,
    input  logic          nmi_req,
    input  logic          nmi_en,
    output exc_kind_e     kind,
    output logic [VW-1:0] vec
);

    logic irq_ok;
    logic nmi_ok;

    // Purpose: qualify the two interrupt sources with their flags.
    always_comb begin
        irq_ok = irq_req && irq_en && !irq_lock;
        nmi_ok = nmi_req && nmi_en;
    end

    // Purpose: fixed-priority pick of the winning request and its vector.
    always_comb begin
        kind = EK_NONE;
        vec  = '0;
        if (fault_req) begin
            kind = EK_FAULT;
            vec  = fault_vec;
        end else if (trap_req) begin
            kind = EK_TRAP;
            vec  = trap_vec;
        end else if (irq_ok) begin
            kind = EK_IRQ;
            vec  = irq_vec;
        end else if (nmi_ok) begin
            kind = EK_NMI;
            vec  = '0;
        end
    end

endmodule

// File: rtl/exc_regcalc.sv
// Register value calculator: from a snapshot of the core state and the
// chosen kind/vector, computes every write-back value of an entry.
// Assumes: DW >= 2 + CCS_SHIFT + (M_BIT+1) and VW <= EXS_IDX_W.
module exc_regcalc
    import exc_entry_pkg::*;
#(
    parameter int DW    = 32,
    parameter int VW    = 8,
    parameter int DSW   = 2,
    parameter int M_BIT = 9,
    parameter int U_BIT = 8
) (
    input  exc_kind_e      kind,
    input  logic [VW-1:0]  vec,
    input  logic [DW-1:0]  pc,
    input  logic [DW-1:0]  sp,
    input  logic [DW-1:0]  ksp,
    input  logic [DW-1:0]  ccs,
    input  logic [DW-1:0]  ebp,
    input  logic [DSW-1:0] dslot,
    output logic [DW-1:0]  ret_addr,
    output logic [DW-1:0]  exs_val,
    output logic [DW-1:0]  ccs_val,
    output logic           user_mode,
    output logic [DW-1:0]  usp_val,
    output logic [DW-1:0]  sp_val,
    output logic [DW-1:0]  tbl_addr
);

    localparam int KEEP_W = DW - 2 - CCS_SHIFT;

    logic [DW-1:0]        ccs_m;
    logic [EXS_IDX_W-1:0] idx8;

    // Purpose: return address; NMI keeps PC, others back up over a delay slot.
    always_comb begin
        if (kind == EK_NMI) ret_addr = pc;
        else                ret_addr = pc - {{(DW-DSW){1'b0}}, dslot};
    end

    // Purpose: exception-status word with the vector index in its field.
    always_comb begin
        idx8    = EXS_IDX_W'(vec);
        exs_val = '0;
        exs_val[EXS_IDX_LO +: EXS_IDX_W] = idx8;
    end

    // Purpose: clear M for NMI, then apply the condition-code stack shift.
    always_comb begin
        ccs_m = ccs;
        if (kind == EK_NMI) ccs_m[M_BIT] = 1'b0;
        ccs_val = {ccs_m[DW-1:DW-2], ccs_m[KEEP_W-1:0], {CCS_SHIFT{1'b0}}};
    end

    // Purpose: stack pointer swap values when leaving user mode.
    always_comb begin
        user_mode = ccs[U_BIT];
        usp_val   = sp;
        sp_val    = ksp;
    end

    // Purpose: vector table entry address, base plus four bytes per vector.
    always_comb begin
        tbl_addr = ebp + {{(DW-VW-2){1'b0}}, vec, 2'b00};
    end

endmodule

// File: rtl/exc_fetch.sv
// Vector fetch engine: issues one word read with a valid/ready handshake,
// holds the request until ready, then writes PC and pulses done.
// Assumes: mem_rd_data is valid in the cycle mem_rd_ready is high.
module exc_fetch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] start_addr,
    output logic          mem_rd_valid,
    output logic [DW-1:0] mem_rd_addr,
    input  logic          mem_rd_ready,
    input  logic [DW-1:0] mem_rd_data,
    output logic          pc_we,
    output logic [DW-1:0] pc_wd,
    output logic          busy
);

    typedef enum logic {F_IDLE, F_READ} fetch_st_e;

    fetch_st_e st;
    logic      hs;

    // Purpose: decode the handshake and the externally visible state.
    always_comb begin
        mem_rd_valid = (st == F_READ);
        busy         = (st == F_READ);
        hs           = mem_rd_valid && mem_rd_ready;
    end

    // Purpose: fetch state machine and held read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= F_IDLE;
            mem_rd_addr <= '0;
        end else begin
            if (st == F_IDLE && start) begin
                st          <= F_READ;
                mem_rd_addr <= start_addr;
            end else if (hs) begin
                st <= F_IDLE;
            end
        end
    end

    // Purpose: register the handler address and its one-cycle write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_we <= 1'b0;
            pc_wd <= '0;
        end else begin
            pc_we <= hs;
            if (hs) pc_wd <= mem_rd_data;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top: arbitrates requests, snapshots register
// values at acceptance, emits one-cycle write-back strobes, and fetches
// the handler address from the vector table.
// Assumes: the core drops an accepted request by the time excp_clr pulses,
// and holds cur_* stable in the acceptance cycle only.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int DW    = 32,
    parameter int VW    = 8,
    parameter int DSW   = 2,
    parameter int I_BIT = 4,
    parameter int M_BIT = 9,
    parameter int U_BIT = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fault_req,
    input  logic [VW-1:0]  fault_vec,
    input  logic           trap_req,
    input  logic [VW-1:0]  trap_vec,
    input  logic           irq_req,
    input  logic [VW-1:0]  irq_vec,
    input  logic           irq_lock,
    input  logic           nmi_req,
    input  logic [DW-1:0]  cur_pc,
    input  logic [DW-1:0]  cur_sp,
    input  logic [DW-1:0]  cur_ccs,
    input  logic [DW-1:0]  cur_ebp,
    input  logic [DW-1:0]  kern_sp,
    input  logic [DSW-1:0] dslot_cnt,
    output logic           erp_we,
    output logic [DW-1:0]  erp_wd,
    output logic           nrp_we,
    output logic [DW-1:0]  nrp_wd,
    output logic           exs_we,
    output logic [DW-1:0]  exs_wd,
    output logic           ccs_we,
    output logic [DW-1:0]  ccs_wd,
    output logic           usp_we,
    output logic [DW-1:0]  usp_wd,
    output logic           sp_we,
    output logic [DW-1:0]  sp_wd,
    output logic           dslot_clr,
    output logic           mem_rd_valid,
    output logic [DW-1:0]  mem_rd_addr,
    input  logic           mem_rd_ready,
    input  logic [DW-1:0]  mem_rd_data,
    output logic           pc_we,
    output logic [DW-1:0]  pc_wd,
    output logic           excp_clr,
    output logic           busy,
    output logic           done
);

    exc_kind_e     kind;
    logic [VW-1:0] vec;
    logic          accept;
    logic [DW-1:0] ret_addr, exs_val, ccs_val, usp_val, sp_val, tbl_addr;
    logic          user_mode;
    logic          fetch_pc_we;

    exc_arbiter #(.VW(VW)) u_arb (
        .fault_req (fault_req),
        .fault_vec (fault_vec),
        .trap_req  (trap_req),
        .trap_vec  (trap_vec),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_lock  (irq_lock),
        .irq_en    (cur_ccs[I_BIT]),
        .nmi_req   (nmi_req),
        .nmi_en    (cur_ccs[M_BIT]),
        .kind      (kind),
        .vec       (vec)
    );

    exc_regcalc #(
        .DW(DW), .VW(VW), .DSW(DSW), .M_BIT(M_BIT), .U_BIT(U_BIT)
    ) u_calc (
        .kind      (kind),
        .vec       (vec),
        .pc        (cur_pc),
        .sp        (cur_sp),
        .ksp       (kern_sp),
        .ccs       (cur_ccs),
        .ebp       (cur_ebp),
        .dslot     (dslot_cnt),
        .ret_addr  (ret_addr),
        .exs_val   (exs_val),
        .ccs_val   (ccs_val),
        .user_mode (user_mode),
        .usp_val   (usp_val),
        .sp_val    (sp_val),
        .tbl_addr  (tbl_addr)
    );

    // Purpose: a request is taken only when one won and no entry is running.
    always_comb begin
        accept = (kind != EK_NONE) && !busy;
    end

    exc_fetch #(.DW(DW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .start_addr   (tbl_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .pc_we        (fetch_pc_we),
        .pc_wd        (pc_wd),
        .busy         (busy)
    );

    // Purpose: completion strobes all follow the PC write.
    always_comb begin
        pc_we    = fetch_pc_we;
        done     = fetch_pc_we;
        excp_clr = fetch_pc_we;
    end

    // Purpose: one-cycle register write-back strobes after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erp_we    <= 1'b0;
            nrp_we    <= 1'b0;
            exs_we    <= 1'b0;
            ccs_we    <= 1'b0;
            usp_we    <= 1'b0;
            sp_we     <= 1'b0;
            dslot_clr <= 1'b0;
        end else begin
            erp_we    <= accept && (kind != EK_NMI);
            nrp_we    <= accept && (kind == EK_NMI);
            exs_we    <= accept;
            ccs_we    <= accept;
            usp_we    <= accept && user_mode;
            sp_we     <= accept && user_mode;
            dslot_clr <= accept;
        end
    end

    // Purpose: capture write-back data values at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erp_wd <= '0;
            nrp_wd <= '0;
            exs_wd <= '0;
            ccs_wd <= '0;
            usp_wd <= '0;
            sp_wd  <= '0;
        end else if (accept) begin
            erp_wd <= ret_addr;
            nrp_wd <= ret_addr;
            exs_wd <= exs_val;
            ccs_wd <= ccs_val;
            usp_wd <= usp_val;
            sp_wd  <= sp_val;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Protocol checker for exc_entry_seq, attached by bind.
// Assumes: default field positions of the status word and CCS shift.
module exc_entry_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          erp_we,
    input logic          nrp_we,
    input logic          exs_we,
    input logic [DW-1:0] exs_wd,
    input logic          ccs_we,
    input logic [DW-1:0] ccs_wd,
    input logic          usp_we,
    input logic          sp_we,
    input logic          mem_rd_valid,
    input logic [DW-1:0] mem_rd_addr,
    input logic          mem_rd_ready,
    input logic [DW-1:0] mem_rd_data,
    input logic          pc_we,
    input logic [DW-1:0] pc_wd,
    input logic          excp_clr,
    input logic          busy,
    input logic          done
);

    p_ret_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erp_we, nrp_we}));

    p_exs_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exs_we |-> (exs_wd[DW-1:16] == '0 && exs_wd[7:0] == 8'h00));

    p_stack_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        usp_we == sp_we);

    p_ccs_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ccs_we |-> ccs_wd[9:0] == 10'h000);

    p_entry_starts_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (erp_we || nrp_we) |-> (busy && mem_rd_valid && exs_we && ccs_we));

    p_read_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_done_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=>
            (done && pc_we && excp_clr && pc_wd == $past(mem_rd_data)));

    p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_no_entry_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(erp_we || nrp_we));

endmodule

bind exc_entry_seq exc_entry_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .erp_we       (erp_we),
    .nrp_we       (nrp_we),
    .exs_we       (exs_we),
    .exs_wd       (exs_wd),
    .ccs_we       (ccs_we),
    .ccs_wd       (ccs_wd),
    .usp_we       (usp_we),
    .sp_we        (sp_we),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_data  (mem_rd_data),
    .pc_we        (pc_we),
    .pc_wd        (pc_wd),
    .excp_clr     (excp_clr),
    .busy         (busy),
    .done         (done)
);

// File: tb/tb_exc_entry_seq.sv
// Self-checking bench: sweeps request masks, flags, vectors, delay slots
// and read latencies, computing expected write-backs arithmetically.
module tb_exc_entry_seq;

    localparam int DW = 32;
    localparam int VW = 8;
    localparam int DSW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           fault_req = 0, trap_req = 0, irq_req = 0, nmi_req = 0, irq_lock = 0;
    logic [VW-1:0]  fault_vec = 0, trap_vec = 0, irq_vec = 0;
    logic [DW-1:0]  cur_pc = 0, cur_sp = 0, cur_ccs = 0, cur_ebp = 0, kern_sp = 0;
    logic [DSW-1:0] dslot_cnt = 0;
    logic           mem_rd_ready = 0;
    logic [DW-1:0]  mem_rd_data = 0;
    logic           erp_we, nrp_we, exs_we, ccs_we, usp_we, sp_we, dslot_clr;
    logic [DW-1:0]  erp_wd, nrp_wd, exs_wd, ccs_wd, usp_wd, sp_wd;
    logic           mem_rd_valid, pc_we, excp_clr, busy, done;
    logic [DW-1:0]  mem_rd_addr, pc_wd;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n),
        .fault_req(fault_req), .fault_vec(fault_vec),
        .trap_req(trap_req), .trap_vec(trap_vec),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lock(irq_lock),
        .nmi_req(nmi_req),
        .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_ccs(cur_ccs),
        .cur_ebp(cur_ebp), .kern_sp(kern_sp), .dslot_cnt(dslot_cnt),
        .erp_we(erp_we), .erp_wd(erp_wd), .nrp_we(nrp_we), .nrp_wd(nrp_wd),
        .exs_we(exs_we), .exs_wd(exs_wd), .ccs_we(ccs_we), .ccs_wd(ccs_wd),
        .usp_we(usp_we), .usp_wd(usp_wd), .sp_we(sp_we), .sp_wd(sp_wd),
        .dslot_clr(dslot_clr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .pc_we(pc_we), .pc_wd(pc_wd), .excp_clr(excp_clr),
        .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // kind codes: 0 none, 1 fault, 2 trap, 3 irq, 4 nmi
    task automatic run_case(input logic [3:0] rq, input logic [DW-1:0] ccs,
                            input logic lk, input logic [DSW-1:0] ds,
                            input logic [VW-1:0] fv, input logic [VW-1:0] tv,
                            input logic [VW-1:0] iv, input logic [DW-1:0] pc,
                            input logic [DW-1:0] sp, input logic [DW-1:0] ksp,
                            input logic [DW-1:0] ebp, input int lat,
                            input logic [DW-1:0] hdl);
        int            kind;
        logic [VW-1:0] v;
        logic [DW-1:0] c, exp_ccs, exp_addr;
        logic          usr;
        string         ktag;
        kind = 0; v = '0;
        if (rq[0]) begin kind = 1; v = fv; ktag = "R1"; end
        else if (rq[1]) begin kind = 2; v = tv; ktag = "R2"; end
        else if (rq[2] && ccs[4] && !lk) begin kind = 3; v = iv; ktag = "R3"; end
        else if (rq[3] && ccs[9]) begin kind = 4; v = '0; ktag = "R4"; end
        c = ccs;
        if (kind == 4) c[9] = 1'b0;
        exp_ccs  = {c[31:30], c[19:0], 10'b0};
        exp_addr = ebp + 32'(v) * 4;
        usr      = ccs[8];
        fault_req = rq[0]; trap_req = rq[1]; irq_req = rq[2]; nmi_req = rq[3];
        irq_lock = lk; cur_ccs = ccs; dslot_cnt = ds;
        fault_vec = fv; trap_vec = tv; irq_vec = iv;
        cur_pc = pc; cur_sp = sp; kern_sp = ksp; cur_ebp = ebp;
        @(posedge clk); @(negedge clk);
        fault_req = 0; trap_req = 0; irq_req = 0; nmi_req = 0;
        if (kind == 0) begin
            // R3/R4: masked or locked interrupts leave every output idle
            chk("R3 masked: busy", 32'(busy), 0);
            chk("R4 masked: ret strobes", 32'({erp_we, nrp_we}), 0);
            chk("R3 masked: read", 32'(mem_rd_valid), 0);
            return;
        end
        // R5: the right kind won (seen through which return register)
        chk({ktag, "/R5 erp_we"}, 32'(erp_we), 32'(kind != 4));
        chk({ktag, "/R5 nrp_we"}, 32'(nrp_we), 32'(kind == 4));
        if (kind == 4) chk("R4 nrp_wd", nrp_wd, pc);
        else           chk({ktag, "/R7 erp_wd"}, erp_wd, pc - 32'(ds));
        chk("R6 exs_we", 32'(exs_we), 1);
        chk({ktag, "/R6 exs_wd"}, exs_wd, 32'(v) << 8);
        chk("R7 dslot_clr", 32'(dslot_clr), 1);
        chk("R8 usp_we", 32'(usp_we), 32'(usr));
        chk("R8 sp_we", 32'(sp_we), 32'(usr));
        if (usr) begin
            chk("R8 usp_wd", usp_wd, sp);
            chk("R8 sp_wd", sp_wd, ksp);
        end
        chk({ktag, "/R9 ccs_wd"}, ccs_wd, exp_ccs);
        chk("R10 busy", 32'(busy), 1);
        chk("R10 valid", 32'(mem_rd_valid), 1);
        chk({ktag, "/R10 addr"}, mem_rd_addr, exp_addr);
        // R12: hammer requests while busy
        fault_req = 1; trap_req = 1; irq_req = 1; nmi_req = 1; fault_vec = ~fv;
        for (int i = 0; i < lat; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R12 no entry while busy", 32'({erp_we, nrp_we, exs_we}), 0);
            chk("R10 valid held", 32'(mem_rd_valid), 1);
            chk("R10 addr held", mem_rd_addr, exp_addr);
        end
        mem_rd_ready = 1; mem_rd_data = hdl;
        @(posedge clk); @(negedge clk);
        mem_rd_ready = 0;
        fault_req = 0; trap_req = 0; irq_req = 0; nmi_req = 0;
        chk("R12 no entry at handshake", 32'({erp_we, nrp_we}), 0);
        chk("R11 pc_we", 32'(pc_we), 1);
        chk("R11 pc_wd", pc_wd, hdl);
        chk("R11 done", 32'(done), 1);
        chk("R11 excp_clr", 32'(excp_clr), 1);
        chk("R11 busy low", 32'(busy), 0);
        @(posedge clk); @(negedge clk);
        chk("R11 done one cycle", 32'({done, pc_we, excp_clr}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset busy", 32'(busy), 0);
        chk("R11 reset valid", 32'(mem_rd_valid), 0);
        chk("R11 reset strobes", 32'({erp_we, nrp_we, exs_we, ccs_we, pc_we, done}), 0);
        rst_n = 1;
        @(negedge clk);
        // Priority and masking sweep (R1..R5)
        for (int rq = 0; rq < 16; rq++)
            for (int fl = 0; fl < 4; fl++)
                for (int lk = 0; lk < 2; lk++) begin
                    logic [DW-1:0] c;
                    c = 32'hA5C3_5A3C ^ (32'(rq * 8 + fl * 2 + lk) * 32'h0101_0101);
                    c[4] = fl[0];
                    c[9] = fl[1];
                    c[8] = rq[0] ^ rq[2];
                    run_case(4'(rq), c, lk[0], 2'(rq), 8'(rq * 17 + 3), 8'(fl * 31 + 5),
                             8'(lk * 99 + rq), 32'h1000_0000 + 32'(rq * 64 + fl),
                             32'h7FF0_0000 - 32'(rq), 32'h8000_1000 + 32'(fl),
                             32'h0004_0000 + 32'(lk * 4096), fl,
                             32'hC000_0000 ^ 32'(rq * 5 + fl));
                end
        // Trap vector sweep: table address and status field (R2, R6, R10)
        for (int v = 0; v < 256; v++)
            run_case(4'b0010, 32'(v) * 32'h0009_1357, 1'b0, 2'(v), 8'h00, 8'(v), 8'h00,
                     32'h0000_2000 + 32'(v * 2), 32'h1234_5678, 32'h8765_4320,
                     32'hFFFF_FC00 + 32'(v & 3), v % 3, 32'h0BAD_0000 + 32'(v));
        // Delay slot and user-mode sweep for interrupts (R3, R7, R8)
        for (int d = 0; d < 4; d++)
            for (int u = 0; u < 2; u++)
                run_case(4'b0100, 32'hC000_0010 | (32'(u) << 8), 1'b0, 2'(d),
                         8'h00, 8'h00, 8'(8'hF0 + d), 32'(d),
                         32'h5555_0000 + 32'(u), 32'h3333_0000 + 32'(d),
                         32'h0001_0000, 1, 32'h4444_0000 + 32'(d * 2 + u));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule